// File: doc/BRIEF.md
# Sixteen-Function 32-Bit Arithmetic Logic Unit

This is a purely combinational arithmetic logic unit for a simple processor datapath. A 4-bit operation code selects one of sixteen functions of two operands and a carry input. The functions are addition and subtraction with and without carry, reverse subtraction, bitwise logic including bit-clear and invert, passing one operand through, the low word of a product, and two constant outputs. The unit also produces negative, zero, carry and overflow flags. It does not decide whether those flags are stored.

The caller drives both operands, the carry input and the code, and reads the result and flags in the same cycle. The operand width and the way the multiplier is built are parameters. The multiplier can be an inferred operator or an explicit array of shifted partial products.

Top module: `alu16`

## Requirements
- R1: Code 4'b0000 gives A+B. Code 4'b1000 gives A+B+carry_in. Both results are taken modulo 2^WIDTH.
- R2: Code 4'b0001 gives A-B. Code 4'b1001 gives A-B-1+carry_in, so carry_in=1 means no borrow.
- R3: Code 4'b1010 gives B-A. Code 4'b1011 gives B-A-1+carry_in.
- R4: Code 4'b0010 gives A AND B, 4'b0011 gives A OR B, 4'b0100 gives A XOR B, and 4'b1100 gives A AND NOT B.
- R5: Code 4'b0101 outputs A, 4'b0110 outputs B, and 4'b1101 outputs NOT B.
- R6: Code 4'b0111 outputs the low WIDTH bits of the unsigned product A×B.
- R7: Code 4'b1110 outputs all zeros and code 4'b1111 outputs the value 1.
- R8: For every code, flag_n equals the result MSB, and flag_z is 1 exactly when the result is all zeros.
- R9: For the six arithmetic codes (R1–R3), flag_c is the carry out of the unsigned sum. For the subtracting forms this means flag_c=1 when no borrow occurs.
- R10: For the six arithmetic codes, flag_v is 1 exactly when the mathematically exact signed result does not fit in WIDTH bits.
- R11: For every code outside R1–R3, flag_c and flag_v are 0.
- R12: carry_in affects no output except under codes 4'b1000, 4'b1001 and 4'b1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry input for the carry-using forms |
| result | output | WIDTH | Function result |
| flag_n | output | 1 | Result is negative |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry out / no-borrow |
| flag_v | output | 1 | Signed overflow |

## Verification
The bench targets the carry conventions of the subtracting forms, including equal operands with carry_in clear, where A-B-1+carry_in wraps to all ones and flag_c must drop. A design that treats carry_in as a borrow would show the wrong result and carry there. Signed boundary operands such as the most negative value minus one, and the most positive value plus one, expose overflow taken from the wrong operand sign. This matters most in reverse subtraction, where swapping the operands without swapping the overflow inputs gives a wrong flag_v. The bench also toggles carry_in under codes that must ignore it, checks that the product wraps to its low word, and confirms that constant and logic codes leave flag_c and flag_v clear even when the operands would carry.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'b0000,
      OP_SUB   = 4'b0001,
      OP_AND   = 4'b0010,
      OP_OR    = 4'b0011,
      OP_XOR   = 4'b0100,
      OP_PASSA = 4'b0101,
      OP_PASSB = 4'b0110,
      OP_MUL   = 4'b0111,
      OP_ADC   = 4'b1000,
      OP_SBC   = 4'b1001,
      OP_RSB   = 4'b1010,
      OP_RSC   = 4'b1011,
      OP_BIC   = 4'b1100,
      OP_NOTB  = 4'b1101,
      OP_ZERO  = 4'b1110,
      OP_ONE   = 4'b1111
   } alu_op_e;

   typedef enum logic [1:0] {
      GRP_ARITH = 2'd0,
      GRP_LOGIC = 2'd1,
      GRP_MUL   = 2'd2
   } alu_grp_e;

   // adder steering: swap operands, invert second operand, carry source
   typedef enum logic [1:0] {
      CK_ZERO = 2'd0,
      CK_ONE  = 2'd1,
      CK_CIN  = 2'd2
   } carry_src_e;

   typedef struct packed {
      alu_grp_e   grp;
      logic       swap;
      logic       inv_y;
      carry_src_e ksrc;
   } alu_ctl_t;

   function automatic alu_ctl_t decode_op(alu_op_e op);
      alu_ctl_t c;
      c = '{grp: GRP_LOGIC, swap: 1'b0, inv_y: 1'b0, ksrc: CK_ZERO};
      case (op)
         OP_ADD: c = '{grp: GRP_ARITH, swap: 1'b0, inv_y: 1'b0, ksrc: CK_ZERO};
         OP_ADC: c = '{grp: GRP_ARITH, swap: 1'b0, inv_y: 1'b0, ksrc: CK_CIN};
         OP_SUB: c = '{grp: GRP_ARITH, swap: 1'b0, inv_y: 1'b1, ksrc: CK_ONE};
         OP_SBC: c = '{grp: GRP_ARITH, swap: 1'b0, inv_y: 1'b1, ksrc: CK_CIN};
         OP_RSB: c = '{grp: GRP_ARITH, swap: 1'b1, inv_y: 1'b1, ksrc: CK_ONE};
         OP_RSC: c = '{grp: GRP_ARITH, swap: 1'b1, inv_y: 1'b1, ksrc: CK_CIN};
         OP_MUL: c.grp = GRP_MUL;
         default: c.grp = GRP_LOGIC;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] in_x,
   input  logic [WIDTH-1:0] in_y,
   input  logic             inv_y,
   input  logic             carry_k,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] y_eff;
   logic [WIDTH:0]   wide;

   always_comb begin
      y_eff = inv_y ? ~in_y : in_y;
      wide  = {1'b0, in_x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, carry_k};
      sum   = wide[MSB:0];
      cout  = wide[WIDTH];
      ovf   = (in_x[MSB] == y_eff[MSB]) && (wide[MSB] != in_x[MSB]);
   end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
   import alu16_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic [WIDTH-1:0] res
);
   localparam logic [WIDTH-1:0] ONE_VAL = {{(WIDTH-1){1'b0}}, 1'b1};

   always_comb begin
      case (op)
         OP_AND:   res = in_a & in_b;
         OP_OR:    res = in_a | in_b;
         OP_XOR:   res = in_a ^ in_b;
         OP_BIC:   res = in_a & ~in_b;
         OP_PASSA: res = in_a;
         OP_PASSB: res = in_b;
         OP_NOTB:  res = ~in_b;
         OP_ONE:   res = ONE_VAL;
         default:  res = '0;
      endcase
   end
endmodule

// File: rtl/alu16_mul.sv
module alu16_mul #(
   parameter int WIDTH    = 32,
   parameter int MUL_IMPL = 0   // 0: inferred operator, 1: partial-product array
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic [WIDTH-1:0] prod_lo
);
   initial begin
      assert (MUL_IMPL == 0 || MUL_IMPL == 1)
         else $error("alu16_mul: MUL_IMPL must be 0 or 1");
   end

   generate
      if (MUL_IMPL == 0) begin : g_infer
         always_comb prod_lo = in_a * in_b;
      end else begin : g_array
         logic [WIDTH-1:0] acc [WIDTH+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_row
            assign acc[i+1] = acc[i] + (in_b[i] ? (in_a << i) : '0);
         end
         assign prod_lo = acc[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/alu16.sv
module alu16
   import alu16_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int MUL_IMPL = 0
) (
   input  logic [3:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);
   localparam int MSB = WIDTH - 1;

   initial begin
      assert (WIDTH >= 2) else $error("alu16: WIDTH must be at least 2");
   end

   alu_op_e  op;
   alu_ctl_t ctl;
   logic [WIDTH-1:0] add_x, add_y, add_sum, log_res, mul_res;
   logic add_k, add_c, add_v;

   always_comb begin
      op    = alu_op_e'(op_sel);
      ctl   = decode_op(op);
      add_x = ctl.swap ? opnd_b : opnd_a;
      add_y = ctl.swap ? opnd_a : opnd_b;
      case (ctl.ksrc)
         CK_ONE:  add_k = 1'b1;
         CK_CIN:  add_k = carry_in;
         default: add_k = 1'b0;
      endcase
   end

   alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
      .in_x(add_x), .in_y(add_y), .inv_y(ctl.inv_y), .carry_k(add_k),
      .sum(add_sum), .cout(add_c), .ovf(add_v)
   );

   alu16_logic #(.WIDTH(WIDTH)) u_logic (
      .op(op), .in_a(opnd_a), .in_b(opnd_b), .res(log_res)
   );

   alu16_mul #(.WIDTH(WIDTH), .MUL_IMPL(MUL_IMPL)) u_mul (
      .in_a(opnd_a), .in_b(opnd_b), .prod_lo(mul_res)
   );

   always_comb begin
      case (ctl.grp)
         GRP_ARITH: result = add_sum;
         GRP_MUL:   result = mul_res;
         default:   result = log_res;
      endcase
      flag_n = result[MSB];
      flag_z = (result == '0);
      flag_c = (ctl.grp == GRP_ARITH) & add_c;
      flag_v = (ctl.grp == GRP_ARITH) & add_v;
   end
endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
   parameter int WIDTH = 32
) (
   input logic [3:0]       op_sel,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [WIDTH-1:0] result,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_c,
   input logic             flag_v
);
   logic known, arith;
   logic [WIDTH-1:0] prod;

   always_comb begin
      known = !$isunknown({op_sel, opnd_a, opnd_b});
      arith = (op_sel == 4'b0000) || (op_sel == 4'b1000) || (op_sel == 4'b0001) ||
              (op_sel == 4'b1001) || (op_sel == 4'b1010) || (op_sel == 4'b1011);
      prod  = opnd_a * opnd_b;
      if (known) begin
         p_neg_flag_r8: assert (flag_n == result[WIDTH-1])
            else $error("p_neg_flag_r8");
         p_zero_flag_r8: assert (flag_z == (result == '0))
            else $error("p_zero_flag_r8");
         p_cv_clear_r11: assert (arith || (!flag_c && !flag_v))
            else $error("p_cv_clear_r11");
         p_const_r7: assert (op_sel != 4'b1110 || result == '0)
            else $error("p_const_r7");
         p_pass_r5: assert (op_sel != 4'b0101 || result == opnd_a)
            else $error("p_pass_r5");
         p_mul_low_r6: assert (op_sel != 4'b0111 || result == prod)
            else $error("p_mul_low_r6");
      end
   end
endmodule

bind alu16 alu16_checker #(.WIDTH(WIDTH)) u_chk (
   .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
   .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/alu16_test.sv
module alu16_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [3:0]   op_sel = 4'd0;
   logic [W-1:0] opnd_a = '0, opnd_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] result;
   logic flag_n, flag_z, flag_c, flag_v;

   int checks = 0;
   int errors = 0;
   logic [31:0] rng = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu16 #(.WIDTH(W)) uut (
      .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
      .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   typedef struct packed {
      logic [W-1:0] r;
      logic n, z, c, v;
   } exp_t;

   function automatic logic [31:0] next_rnd(logic [31:0] s);
      logic [31:0] t = s;
      t = t ^ (t << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   // x - y - 1 + k with borrow / overflow from exact integer values
   function automatic exp_t sub_model(logic [W-1:0] x, logic [W-1:0] y, logic k);
      exp_t e;
      longint ux, uy, sx, sy, ud, sd;
      ux = longint'({32'd0, x});
      uy = longint'({32'd0, y});
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      ud = ux - uy - 1 + longint'(k);
      sd = sx - sy - 1 + longint'(k);
      e.r = ud[W-1:0];
      e.c = (ud >= 0);
      e.v = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
      return e;
   endfunction

   function automatic exp_t model(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b, logic ci);
      exp_t e;
      longint us, ss;
      e = '0;
      case (op)
         4'b0000, 4'b1000: begin
            us = longint'({32'd0, a}) + longint'({32'd0, b}) + ((op == 4'b1000) ? longint'(ci) : 0);
            ss = longint'($signed(a)) + longint'($signed(b)) + ((op == 4'b1000) ? longint'(ci) : 0);
            e.r = us[W-1:0];
            e.c = (us > 64'sd4294967295);
            e.v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
         end
         4'b0001: e = sub_model(a, b, 1'b1);
         4'b1001: e = sub_model(a, b, ci);
         4'b1010: e = sub_model(b, a, 1'b1);
         4'b1011: e = sub_model(b, a, ci);
         4'b0010: e.r = a & b;
         4'b0011: e.r = a | b;
         4'b0100: e.r = a ^ b;
         4'b1100: e.r = a & ~b;
         4'b0101: e.r = a;
         4'b0110: e.r = b;
         4'b1101: e.r = ~b;
         4'b0111: begin
            logic [63:0] p = {32'd0, a} * {32'd0, b};
            e.r = p[W-1:0];
         end
         4'b1110: e.r = '0;
         default: e.r = 32'd1;
      endcase
      e.n = e.r[W-1];
      e.z = (e.r == '0);
      return e;
   endfunction

   task automatic check(string tag, exp_t got, exp_t exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: op=%b a=%h b=%h cin=%b got r=%h nzcv=%b%b%b%b exp r=%h nzcv=%b%b%b%b",
                  tag, op_sel, opnd_a, opnd_b, carry_in,
                  got.r, got.n, got.z, got.c, got.v, exp.r, exp.n, exp.z, exp.c, exp.v);
      end
   endtask

   task automatic run_op(string tag, logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b, logic ci);
      exp_t got;
      @(posedge clk);
      op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci;
      @(negedge clk);
      got = '{r: result, n: flag_n, z: flag_z, c: flag_c, v: flag_v};
      check(tag, got, model(op, a, b, ci));
   endtask

   task automatic t_reset_state;
      run_op("R8 idle zero", 4'b0000, '0, '0, 1'b0);
   endtask

   task automatic t_add;
      run_op("R1 add", 4'b0000, 32'd100, 32'd23, 1'b1);
      run_op("R1 adc", 4'b1000, 32'd100, 32'd23, 1'b1);
      run_op("R9 add carry", 4'b0000, 32'hFFFF_FFFF, 32'd1, 1'b0);
      run_op("R10 add ovf", 4'b0000, 32'h7FFF_FFFF, 32'd1, 1'b0);
      run_op("R9 adc wrap", 4'b1000, 32'hFFFF_FFFF, 32'd0, 1'b1);
   endtask

   task automatic t_sub;
      run_op("R2 sub", 4'b0001, 32'd50, 32'd8, 1'b0);
      run_op("R9 sub borrow", 4'b0001, 32'd3, 32'd5, 1'b0);
      run_op("R10 sub ovf", 4'b0001, 32'h8000_0000, 32'd1, 1'b0);
      run_op("R2 sbc eq cin0", 4'b1001, 32'd7, 32'd7, 1'b0);
      run_op("R2 sbc eq cin1", 4'b1001, 32'd7, 32'd7, 1'b1);
   endtask

   task automatic t_reverse;
      run_op("R3 rsb", 4'b1010, 32'd5, 32'd20, 1'b0);
      run_op("R3 rsb borrow", 4'b1010, 32'd20, 32'd5, 1'b0);
      run_op("R10 rsb ovf", 4'b1010, 32'd1, 32'h8000_0000, 1'b0);
      run_op("R3 rsc cin0", 4'b1011, 32'd5, 32'd20, 1'b0);
      run_op("R3 rsc cin1", 4'b1011, 32'd5, 32'd20, 1'b1);
   endtask

   task automatic t_logic;
      run_op("R4 and", 4'b0010, 32'hF0F0_FF00, 32'hFF00_0FF0, 1'b0);
      run_op("R4 or", 4'b0011, 32'hF0F0_FF00, 32'hFF00_0FF0, 1'b0);
      run_op("R4 xor", 4'b0100, 32'hF0F0_FF00, 32'hFF00_0FF0, 1'b0);
      run_op("R4 bic", 4'b1100, 32'hF0F0_FF00, 32'hFF00_0FF0, 1'b0);
      run_op("R11 and no cv", 4'b0010, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1);
   endtask

   task automatic t_pass;
      run_op("R5 passa", 4'b0101, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1);
      run_op("R5 passb", 4'b0110, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
      run_op("R5 notb", 4'b1101, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0);
   endtask

   task automatic t_mul;
      run_op("R6 mul", 4'b0111, 32'd1234, 32'd5678, 1'b0);
      run_op("R6 mul wrap", 4'b0111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
      run_op("R6 mul hi", 4'b0111, 32'h0001_0000, 32'h0001_0000, 1'b0);
   endtask

   task automatic t_const;
      run_op("R7 zero", 4'b1110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
      run_op("R7 one", 4'b1111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
   endtask

   // carry_in toggled under codes that must ignore it
   task automatic t_cin_ignored;
      logic [3:0] ign [10] = '{4'b0000, 4'b0001, 4'b1010, 4'b0010, 4'b0011,
                               4'b0100, 4'b0110, 4'b0111, 4'b1100, 4'b1101};
      for (int i = 0; i < 10; i++) begin
         run_op("R12 cin0", ign[i], 32'h8765_4321, 32'h0F0F_1234, 1'b0);
         run_op("R12 cin1", ign[i], 32'h8765_4321, 32'h0F0F_1234, 1'b1);
      end
   endtask

   task automatic t_sweep;
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] a, b;
         rng = next_rnd(rng); a = rng;
         rng = next_rnd(rng); b = (i % 7 == 0) ? a : rng;
         run_op("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 sweep", 4'(i % 16), a, b, rng[3]);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_reset_state();
      t_add();
      t_sub();
      t_reverse();
      t_logic();
      t_pass();
      t_mul();
      t_const();
      t_cin_ignored();
      t_sweep();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule